// File: doc/BRIEF.md
# Serial EEPROM Pin Arbiter

This block decides who owns the four wires of a serial EEPROM port: select, serial clock, data toward the memory, and data returned by the memory. Three owners compete, in fixed priority order. The system reset pin comes first. Next comes a configuration read in progress, either the automatic read that follows reset or a read that software requests. Last comes a software bit-bang register, which drives the pins only when its enable bit is set. With the enable bit clear and no read running, the clock and data-in wires become LED outputs, and select is held low.

The protocol and checksum engine sit outside this block and talk to it through a request/done/pass handshake. The engine supplies select and data-in while its request is high. This block generates the serial clock at the system clock divided by `DIV`. A detect strap tells the block whether a memory is fitted. When the strap is low, a software-requested read produces exactly `ABORT_CYC` serial clock periods and is then abandoned. The automatic read after reset always runs to completion.

The control word is eight bits:

| Bit | Name | Write | Read |
|-----|------|-------|------|
| 0 | DAT | data-in value | live data-out input |
| 1 | CLK | clock value | stored value |
| 2 | SEL | select value | stored value |
| 4 | ENA | bit-bang enable | stored value |
| 7 | RDREQ | writing 1 requests a read | request pending |

All other bits read as 0.

Top module: `eep_pin_arbiter`

## Requirements
- R1: While `rst_n` is low, `ee_cs` is 0 and both `ee_sk_oe` and `ee_di_oe` are 0.
- R2: While a read is in progress (the sequencer is active or RDREQ, bit 7, is 1), the read path owns the pins even if ENA is 1.
  - During an engine read, `ee_cs` and `ee_di` follow `eng_cs` and `eng_di`.
  - `ee_sk` is low for the first DIV/2 cycles of each DIV-cycle period and high for the rest, starting low.
- R3: With no read in progress and ENA (bit 4) set to 1, `ee_cs`, `ee_sk` and `ee_di` equal the stored SEL (bit 2), CLK (bit 1) and DAT (bit 0) values.
- R4: With no read in progress and ENA at 0, `ee_cs` is 0, `ee_sk` equals `led1_in`, `ee_di` equals `led0_in`, and both enables are 1.
- R5: A write to CLK or DAT reaches its pin at the clock edge that samples the write, not before.
- R6: Bit 0 of `reg_rdata` always shows the present level of `ee_do`.
- R7: After reset the register holds CLK=1, DAT=0, SEL=0, ENA=0 and RDREQ=0, and `cfg_valid` is 0.
- R8: CLK and DAT accept a write only while `halt_sts` is 1; SEL and ENA accept writes at any time.
- R9: With `det_strap` at 0, setting RDREQ gives exactly ABORT_CYC (2) rising edges of `ee_sk` in DIV*ABORT_CYC cycles with `eng_req` never high. The read then ends and `cfg_valid` is 0.
- R10: With `det_strap` at 1, setting RDREQ raises `eng_req` until `eng_done`, and `cfg_valid` then takes `eng_pass`.
- R11: Leaving reset starts an automatic read whatever the strap: `eng_req` is 1 from the first cycle, and `cfg_valid` takes `eng_pass` at `eng_done`.
- R12: RDREQ clears in the cycle a software read finishes or aborts. A write of RDREQ while any read is active is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| halt_sts | input | 1 | Stop-or-suspend status, gates CLK/DAT writes |
| det_strap | input | 1 | 1 when an EEPROM is fitted |
| led1_in | input | 1 | LED level placed on the clock pin in LED mode |
| led0_in | input | 1 | LED level placed on the data-in pin in LED mode |
| eng_req | output | 1 | Read engine request |
| eng_cs | input | 1 | Engine select value |
| eng_di | input | 1 | Engine data-in value |
| eng_done | input | 1 | Engine finished pulse |
| eng_pass | input | 1 | Checksum result, valid with eng_done |
| cfg_valid | output | 1 | Last read produced valid contents |
| ee_cs | output | 1 | EEPROM select |
| ee_sk | output | 1 | EEPROM serial clock / LED1 |
| ee_sk_oe | output | 1 | Drive enable for ee_sk |
| ee_di | output | 1 | Data to EEPROM / LED0 |
| ee_di_oe | output | 1 | Drive enable for ee_di |
| ee_do | input | 1 | Data from EEPROM |

## Verification
The pin mux is combinational, so LED levels, `ee_do` readback and the reset-driven pin states are checked a time step after the input changes, in the same cycle. Register writes, RDREQ clearing and `cfg_valid` updates land one edge after the sampled strobe or `eng_done`. The checks look just before that edge to confirm nothing moved early, and at the following falling edge for the new value. The serial clock is sampled once per cycle at falling edges from the cycle the request is taken. This gives an exact cycle-by-cycle pattern, a rising-edge count, and a busy-cycle count of DIV*ABORT_CYC+1 for the aborted read.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int REG_W = 8;
    localparam int B_DAT = 0;
    localparam int B_CLK = 1;
    localparam int B_SEL = 2;
    localparam int B_ENA = 4;
    localparam int B_RRQ = 7;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_AUTO  = 2'd1,
        RS_FULL  = 2'd2,
        RS_ABORT = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic sel;
        logic sk;
        logic di;
        logic ena;
        logic rrq;
    } ctl_bits_t;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pin_drv_t;

endpackage

// File: rtl/eep_ctrl_reg.sv
module eep_ctrl_reg
    import eep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             halt,
    input  logic             seq_active,
    input  logic             rd_clr,
    input  logic             ee_do,
    output ctl_bits_t        ctl,
    output logic [REG_W-1:0] rdata
);

    ctl_bits_t q, d;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[6:5], wdata[3]};

    always_comb begin
        d = q;
        if (wr) begin
            d.sel = wdata[B_SEL];
            d.ena = wdata[B_ENA];
            if (halt) begin
                d.sk = wdata[B_CLK];
                d.di = wdata[B_DAT];
            end
            if (wdata[B_RRQ] && !q.rrq && !seq_active) begin
                d.rrq = 1'b1;
            end
        end
        if (rd_clr) begin
            d.rrq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sel: 1'b0, sk: 1'b1, di: 1'b0, ena: 1'b0, rrq: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata        = '0;
        rdata[B_DAT] = ee_do;
        rdata[B_CLK] = q.sk;
        rdata[B_SEL] = q.sel;
        rdata[B_ENA] = q.ena;
        rdata[B_RRQ] = q.rrq;
    end

    assign ctl = q;

    // R8
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !halt) |=> ($stable(q.sk) && $stable(q.di)));

    // R12
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> !q.rrq);

endmodule

// File: rtl/eep_read_seq.sv
module eep_read_seq
    import eep_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int ABORT_CYC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rrq,
    input  logic     strap,
    input  logic     eng_done,
    input  logic     eng_pass,
    input  logic     eng_cs,
    input  logic     eng_di,
    output logic     active,
    output logic     eng_req,
    output logic     rd_clr,
    output pin_drv_t drv,
    output logic     valid
);

    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int NC_W = (ABORT_CYC > 1) ? $clog2(ABORT_CYC) : 1;
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);
    localparam logic [NC_W-1:0] NC_MAX = NC_W'(ABORT_CYC - 1);

    typedef struct packed {
        rd_state_e       st;
        logic [PH_W-1:0] ph;
        logic [NC_W-1:0] nc;
        logic            valid;
    } seq_t;

    seq_t q, d;
    logic ph_wrap;
    logic abort_end;

    always_comb begin
        d         = q;
        rd_clr    = 1'b0;
        abort_end = 1'b0;
        ph_wrap   = (q.ph == PH_MAX);
        case (q.st)
            RS_IDLE: begin
                d.ph = '0;
                d.nc = '0;
                if (rrq) begin
                    d.st = strap ? RS_FULL : RS_ABORT;
                end
            end
            RS_AUTO, RS_FULL: begin
                d.ph = ph_wrap ? '0 : q.ph + 1'b1;
                if (eng_done) begin
                    d.st    = RS_IDLE;
                    d.valid = eng_pass;
                    rd_clr  = (q.st == RS_FULL);
                end
            end
            RS_ABORT: begin
                d.ph = ph_wrap ? '0 : q.ph + 1'b1;
                if (ph_wrap) begin
                    if (q.nc == NC_MAX) begin
                        d.st      = RS_IDLE;
                        d.valid   = 1'b0;
                        rd_clr    = 1'b1;
                        abort_end = 1'b1;
                    end else begin
                        d.nc = q.nc + 1'b1;
                    end
                end
            end
            default: d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RS_AUTO, ph: '0, nc: '0, valid: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        drv = '0;
        if (q.st != RS_IDLE) begin
            drv.sk = (q.ph >= PH_HALF);
            drv.cs = (q.st == RS_ABORT) ? 1'b1 : eng_cs;
            drv.di = (q.st == RS_ABORT) ? 1'b0 : eng_di;
        end
    end

    assign active  = (q.st != RS_IDLE);
    assign eng_req = rst_n && ((q.st == RS_AUTO) || (q.st == RS_FULL));
    assign valid   = q.valid;

    // R2
    sk_rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $rose(drv.sk)) |-> (q.ph == PH_HALF));

    // R9
    abort_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_end |=> (!q.valid && q.st == RS_IDLE));

    // R10
    full_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RS_FULL && eng_done) |=> (q.valid == $past(eng_pass)));

    // R9
    abort_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RS_ABORT) |-> !eng_req);

endmodule

// File: rtl/eep_pin_mux.sv
module eep_pin_mux
    import eep_pkg::*;
(
    input  logic     rst_n,
    input  logic     rd_busy,
    input  pin_drv_t rd_drv,
    input  logic     bb_ena,
    input  logic     bb_sel,
    input  logic     bb_sk,
    input  logic     bb_di,
    input  logic     led1,
    input  logic     led0,
    output logic     cs,
    output logic     sk,
    output logic     sk_oe,
    output logic     di,
    output logic     di_oe
);

    always_comb begin
        cs    = 1'b0;
        sk    = 1'b0;
        di    = 1'b0;
        sk_oe = 1'b1;
        di_oe = 1'b1;
        if (!rst_n) begin
            sk_oe = 1'b0;
            di_oe = 1'b0;
        end else if (rd_busy) begin
            cs = rd_drv.cs;
            sk = rd_drv.sk;
            di = rd_drv.di;
        end else if (bb_ena) begin
            cs = bb_sel;
            sk = bb_sk;
            di = bb_di;
        end else begin
            sk = led1;
            di = led0;
        end
    end

endmodule

// File: rtl/eep_pin_arbiter.sv
module eep_pin_arbiter
    import eep_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int ABORT_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       halt_sts,
    input  logic       det_strap,
    input  logic       led1_in,
    input  logic       led0_in,
    output logic       eng_req,
    input  logic       eng_cs,
    input  logic       eng_di,
    input  logic       eng_done,
    input  logic       eng_pass,
    output logic       cfg_valid,
    output logic       ee_cs,
    output logic       ee_sk,
    output logic       ee_sk_oe,
    output logic       ee_di,
    output logic       ee_di_oe,
    input  logic       ee_do
);

    ctl_bits_t ctl;
    pin_drv_t  rd_drv;
    logic      seq_active;
    logic      rd_clr;
    logic      rd_busy;

    eep_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .halt       (halt_sts),
        .seq_active (seq_active),
        .rd_clr     (rd_clr),
        .ee_do      (ee_do),
        .ctl        (ctl),
        .rdata      (reg_rdata)
    );

    eep_read_seq #(
        .DIV       (DIV),
        .ABORT_CYC (ABORT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rrq      (ctl.rrq),
        .strap    (det_strap),
        .eng_done (eng_done),
        .eng_pass (eng_pass),
        .eng_cs   (eng_cs),
        .eng_di   (eng_di),
        .active   (seq_active),
        .eng_req  (eng_req),
        .rd_clr   (rd_clr),
        .drv      (rd_drv),
        .valid    (cfg_valid)
    );

    assign rd_busy = seq_active || ctl.rrq;

    eep_pin_mux u_mux (
        .rst_n   (rst_n),
        .rd_busy (rd_busy),
        .rd_drv  (rd_drv),
        .bb_ena  (ctl.ena),
        .bb_sel  (ctl.sel),
        .bb_sk   (ctl.sk),
        .bb_di   (ctl.di),
        .led1    (led1_in),
        .led0    (led0_in),
        .cs      (ee_cs),
        .sk      (ee_sk),
        .sk_oe   (ee_sk_oe),
        .di      (ee_di),
        .di_oe   (ee_di_oe)
    );

    // R3
    bitbang_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_busy && ctl.ena) |-> (ee_cs == ctl.sel && ee_sk == ctl.sk && ee_di == ctl.di));

    // R4
    led_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_busy && !ctl.ena) |-> (!ee_cs && ee_sk == led1_in && ee_di == led0_in));

    // R2
    engine_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (ee_cs == eng_cs && ee_di == eng_di && ee_sk_oe && ee_di_oe));

    // R6
    do_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_DAT] == ee_do);

endmodule

// File: tb/sim_eep_pin_arbiter.sv
module sim_eep_pin_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       halt_sts = 1'b0;
    logic       det_strap = 1'b0;
    logic       led1_in = 1'b0;
    logic       led0_in = 1'b0;
    logic       eng_req;
    logic       eng_cs = 1'b0;
    logic       eng_di = 1'b0;
    logic       eng_done = 1'b0;
    logic       eng_pass = 1'b0;
    logic       cfg_valid;
    logic       ee_cs, ee_sk, ee_sk_oe, ee_di, ee_di_oe;
    logic       ee_do = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    eep_pin_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .halt_sts(halt_sts), .det_strap(det_strap),
        .led1_in(led1_in), .led0_in(led0_in), .eng_req(eng_req),
        .eng_cs(eng_cs), .eng_di(eng_di), .eng_done(eng_done),
        .eng_pass(eng_pass), .cfg_valid(cfg_valid), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_sk_oe(ee_sk_oe), .ee_di(ee_di),
        .ee_di_oe(ee_di_oe), .ee_do(ee_do)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_done(input logic pass);
        @(negedge clk);
        eng_done = 1'b1;
        eng_pass = pass;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // R1 R7 R11 R2 R12: reset, automatic read
    task automatic t_reset_auto();
        logic [4:0] pat;
        rst_n = 1'b0;
        det_strap = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset pins", {5'd0, ee_cs, ee_sk_oe, ee_di_oe}, 8'h00);
        eng_cs = 1'b1;
        eng_di = 1'b1;
        rst_n = 1'b1;
        #1;
        check("R11 auto req", {7'd0, eng_req}, 8'h01);
        check("R7 reset reg", reg_rdata, 8'h02);
        check("R7 valid reset", {7'd0, cfg_valid}, 8'h00);
        check("R2 engine owns pins", {6'd0, ee_cs, ee_di}, 8'h03);
        pat[4] = ee_sk;
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk);
            pat[i] = ee_sk;
        end
        check("R2 sk pattern", {3'd0, pat}, 8'b0000_0110);
        write_reg(8'h80);
        check("R12 rdreq ignored during auto", {7'd0, reg_rdata[7]}, 8'h00);
        pulse_done(1'b1);
        check("R11 auto valid", {6'd0, cfg_valid, eng_req}, 8'h02);
        repeat (2) @(negedge clk);
        check("R12 no read after auto", {6'd0, reg_rdata[7], eng_req}, 8'h00);
    endtask

    // R4: LED mode
    task automatic t_led();
        @(negedge clk);
        led1_in = 1'b1;
        led0_in = 1'b0;
        #1;
        check("R4 led a", {4'd0, ee_cs, ee_sk, ee_di, ee_sk_oe & ee_di_oe}, 8'h05);
        led1_in = 1'b0;
        led0_in = 1'b1;
        #1;
        check("R4 led b", {4'd0, ee_cs, ee_sk, ee_di, ee_sk_oe & ee_di_oe}, 8'h03);
    endtask

    // R3 R5: bit-bang with halt set
    task automatic t_bitbang();
        halt_sts = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 8'h15;
        #1;
        check("R5 not before edge", {6'd0, ee_sk, ee_di}, 8'h01);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R3 R5 pins after edge", {5'd0, ee_cs, ee_sk, ee_di}, 8'h05);
        check("R3 readback", reg_rdata & 8'hFE, 8'h14);
        write_reg(8'h12);
        check("R3 second write", {5'd0, ee_cs, ee_sk, ee_di}, 8'h02);
    endtask

    // R8: halt gating
    task automatic t_halt();
        halt_sts = 1'b0;
        write_reg(8'h15);
        check("R8 clk/dat kept", {6'd0, ee_sk, ee_di}, 8'h02);
        check("R8 sel taken", {7'd0, ee_cs}, 8'h01);
        check("R8 readback", reg_rdata & 8'hFE, 8'h16);
        halt_sts = 1'b1;
    endtask

    // R6: live data-out
    task automatic t_do();
        ee_do = 1'b1;
        #1;
        check("R6 do high", {7'd0, reg_rdata[0]}, 8'h01);
        ee_do = 1'b0;
        #1;
        check("R6 do low", {7'd0, reg_rdata[0]}, 8'h00);
    endtask

    // R9 R12: aborted software read
    task automatic t_abort();
        int busy;
        int rises;
        int reqs;
        logic prev;
        det_strap = 1'b0;
        busy = 0;
        rises = 0;
        reqs = 0;
        prev = 1'b0;
        write_reg(8'h90);
        for (int i = 0; i < 20; i++) begin
            if (reg_rdata[7]) busy++;
            if (ee_sk && !prev) rises++;
            if (eng_req) reqs++;
            prev = ee_sk;
            @(negedge clk);
        end
        check("R9 sk rises", 8'(rises), 8'd2);
        check("R9 busy cycles", 8'(busy), 8'd9);
        check("R9 no engine req", 8'(reqs), 8'd0);
        check("R9 valid cleared", {7'd0, cfg_valid}, 8'h00);
        check("R12 rdreq cleared", {7'd0, reg_rdata[7]}, 8'h00);
    endtask

    // R10 R2 R12: full software read
    task automatic t_full(input logic pass);
        det_strap = 1'b1;
        eng_cs = 1'b1;
        eng_di = 1'b0;
        write_reg(8'h91);
        repeat (2) @(negedge clk);
        check("R10 eng req", {7'd0, eng_req}, 8'h01);
        check("R2 priority over ena", {6'd0, ee_cs, ee_di}, 8'h02);
        write_reg(8'h90);
        check("R12 still pending", {7'd0, reg_rdata[7]}, 8'h01);
        pulse_done(pass);
        check("R10 valid result", {7'd0, cfg_valid}, {7'd0, pass});
        check("R12 cleared on done", {6'd0, reg_rdata[7], eng_req}, 8'h00);
        repeat (2) @(negedge clk);
        check("R12 no restart", {7'd0, eng_req}, 8'h00);
    endtask

    // R1 R7: reset during bit-bang
    task automatic t_reset_again();
        write_reg(8'h14);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset overrides", {5'd0, ee_cs, ee_sk_oe, ee_di_oe}, 8'h00);
        check("R7 reg after reset", reg_rdata, 8'h02);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset_auto();
        t_led();
        t_bitbang();
        t_halt();
        t_do();
        t_abort();
        t_full(1'b0);
        t_full(1'b1);
        t_reset_again();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule